// File: doc/BRIEF.md
# Central Bus Arbitration Controller

This block sits at the single central point of a shared bus that several masters use. Every other agent on the bus takes part in arbitration. The controller watches an active-low preempt line, which any agent can pull low to ask for the bus. It also drives one phase signal, which is high while arbitration runs and low while the bus is granted. Agents resolve their 4-bit priority levels among themselves on a shared arbitration bus, where a lower value beats a higher one. After a fixed settle time the controller samples the resolved level and grants the bus to that level. Level 0 belongs to the nonmaskable-interrupt requester. Level 15 means that no agent is asking, and the processor keeps the bus by default.

An owner can hold the active-low burst line low to keep the bus across several transfers. A preempt still overrides a burst. The phase signal goes to arbitration at once, and the controller then waits for the owner to release burst. If the owner has not released within a fixed deadline, a sticky bus error is raised, and the bus stays in arbitration until software-side logic pulses a synchronous clear.

A refresh pacer inside the block raises a refresh request at a fixed period. A refresh request opens arbitration on its own. At the next sample it wins over every level on the bus, including the interrupt level. Refresh then holds the bus for a short fixed tenure, after which a fresh arbitration hands the bus back.

Top module: `bus_arbiter_hub`

## Requirements
- R1: After reset, arb_phase is 0, owner_lvl is 4'hF (the processor default owner), refresh_own is 0 and bus_err is 0.
- R2: While the bus is granted and neither a preempt nor a refresh request is pending, arb_phase stays 0 and owner_lvl keeps its value, whatever arb_bus and burst_n do.
- R3: When preempt_n is sampled low at a rising edge during the grant phase and burst_n is high, arb_phase is 1 after that edge.
- R4: An arbitration phase lasts SETTLE_CYC rising edges. At the last of these edges, arb_bus is latched into owner_lvl and arb_phase returns to 0. Lower values have higher priority, 4'h0 is the interrupt level, and 4'hF means no requester.
- R5: When a preempt arrives while burst_n is low, arb_phase becomes 1 at the same edge. The SETTLE_CYC count starts only at the edge where burst_n is first seen high.
- R6: If burst_n is still low at each of the TMO_CYC rising edges that follow the preempt edge, bus_err is 1 after the last of those edges. arb_phase stays 1 for as long as bus_err is 1.
- R7: bus_err is sticky. err_clr sampled high clears it at that edge and starts a new arbitration, which grants SETTLE_CYC edges later.
- R8: A refresh request is raised at edge number REF_PERIOD after reset and every REF_PERIOD edges after that. At the next grant-phase edge it opens arbitration, and at the sample it wins regardless of arb_bus, even a level-0 requester. refresh_own is then 1 with arb_phase 0 for REF_LEN edges, after which a new arbitration starts.
- R9: If burst_n is seen high at or before the TMO_CYC-th edge after the preempt, no bus error is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| preempt_n | input | 1 | Active-low bus request from any agent |
| burst_n | input | 1 | Active-low burst hold from the current owner |
| arb_bus | input | 4 | Resolved arbitration level; lower value wins |
| err_clr | input | 1 | Synchronous clear of the bus error |
| arb_phase | output | 1 | 1 = arbitration phase, 0 = grant phase |
| owner_lvl | output | 4 | Level latched at the last arbitration sample |
| refresh_own | output | 1 | Refresh holds the bus |
| bus_err | output | 1 | Sticky release-timeout error |

## Verification
A preempt, a refresh request or an error clear changes arb_phase one edge after it is sampled. The new owner_lvl and the return to grant follow exactly SETTLE_CYC edges after arbitration opens, or after burst_n is released when a burst was in progress. The timeout flag appears on the TMO_CYC-th edge after the preempt. All inputs are driven, and all outputs read, a quarter period after a rising edge. The bench counts edges from each stimulus to the expected due edge, and it checks both the edge before the change and the edge of the change. It sweeps every pair of agent levels and every burst release point from the first edge to one past the deadline.

// File: rtl/arbc_pkg.sv
`timescale 1ns/1ps
package arbc_pkg;

  typedef enum logic [2:0] {
    ST_GRANT,
    ST_DRAIN,
    ST_ARB,
    ST_REFR,
    ST_HALT
  } arbc_state_e;

  localparam logic [3:0] LVL_NMI  = 4'h0;
  localparam logic [3:0] LVL_IDLE = 4'hF;

  // width that holds every count from 0 to max(a,b,c)-1
  function automatic int unsigned f_cnt_width(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

  // true when a zero-based count sits on the last cycle of a window
  function automatic logic f_is_last(int unsigned cnt, int unsigned len);
    return (cnt + 1) == len;
  endfunction

endpackage

// File: rtl/arbc_refresh_pacer.sv
`timescale 1ns/1ps
module arbc_refresh_pacer #(
  parameter int unsigned PERIOD = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  output logic pend
);
  import arbc_pkg::*;

  localparam int unsigned RW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [RW-1:0] tick_q;
  logic          pend_q;
  logic          ev_wrap;

  assign ev_wrap = f_is_last(32'(tick_q), PERIOD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      pend_q <= 1'b0;
    end else begin
      tick_q <= ev_wrap ? '0 : tick_q + RW'(1);
      if (ev_wrap)   pend_q <= 1'b1;
      else if (take) pend_q <= 1'b0;
    end
  end

  assign pend = pend_q;

  AST_WRAP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wrap |=> pend_q); // R8
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !take) |=> pend_q); // R8

endmodule

// File: rtl/arbc_seq.sv
`timescale 1ns/1ps
module arbc_seq #(
  parameter int unsigned SETTLE_CYC = 4,
  parameter int unsigned TMO_CYC    = 78,
  parameter int unsigned REF_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic preempt_n,
  input  logic burst_n,
  input  logic ref_pend,
  input  logic err_clr,
  output logic arb_phase,
  output logic in_refresh,
  output logic err,
  output logic ev_sample,
  output logic ref_take
);
  import arbc_pkg::*;

  localparam int unsigned CW = f_cnt_width(SETTLE_CYC, TMO_CYC, REF_LEN);

  arbc_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          err_q;

  // named events for the checks below
  logic ev_start, ev_release, ev_timeout, ev_rdone, ev_clear;

  assign ev_start   = (state_q == ST_GRANT) && (!preempt_n || ref_pend);
  assign ev_release = (state_q == ST_DRAIN) && burst_n;
  assign ev_timeout = (state_q == ST_DRAIN) && !burst_n && f_is_last(32'(cnt_q), TMO_CYC);
  assign ev_sample  = (state_q == ST_ARB)   && f_is_last(32'(cnt_q), SETTLE_CYC);
  assign ev_rdone   = (state_q == ST_REFR)  && f_is_last(32'(cnt_q), REF_LEN);
  assign ev_clear   = (state_q == ST_HALT)  && err_clr;
  assign ref_take   = ev_sample && ref_pend;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_GRANT: if (ev_start) state_d = burst_n ? ST_ARB : ST_DRAIN;
      ST_DRAIN: begin
        if (ev_release)      state_d = ST_ARB;
        else if (ev_timeout) state_d = ST_HALT;
      end
      ST_ARB:   if (ev_sample) state_d = ref_pend ? ST_REFR : ST_GRANT;
      ST_REFR:  if (ev_rdone)  state_d = ST_ARB;
      ST_HALT:  if (ev_clear)  state_d = ST_ARB;
      default:  state_d = ST_GRANT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_GRANT;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q) cnt_q <= '0;
      else if (state_q inside {ST_DRAIN, ST_ARB, ST_REFR}) cnt_q <= cnt_q + CW'(1);
      if (ev_timeout)   err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  assign arb_phase  = (state_q == ST_DRAIN) || (state_q == ST_ARB) || (state_q == ST_HALT);
  assign in_refresh = (state_q == ST_REFR);
  assign err        = err_q;

  AST_PREEMPT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> arb_phase); // R3
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GRANT && preempt_n && !ref_pend) |=> !arb_phase); // R2
  AST_SAMPLE_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sample && !ref_pend) |=> !arb_phase); // R4
  AST_TIMEOUT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> err); // R6
  AST_ERR_HOLDS_ARB: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> arb_phase); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err); // R7
  AST_REF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ref_take |=> (in_refresh && !arb_phase)); // R8

endmodule

// File: rtl/arbc_level_latch.sv
`timescale 1ns/1ps
module arbc_level_latch #(
  parameter int unsigned LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] arb_bus,
  output logic [LW-1:0] owner_lvl
);
  logic [LW-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lvl_q <= '1;
    else if (load) lvl_q <= arb_bus;
  end

  assign owner_lvl = lvl_q;

  AST_LOAD_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (owner_lvl == $past(arb_bus))); // R4
  AST_OWNER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(owner_lvl)); // R2

endmodule

// File: rtl/bus_arbiter_hub.sv
`timescale 1ns/1ps
module bus_arbiter_hub #(
  parameter int unsigned SETTLE_CYC = 4,
  parameter int unsigned TMO_CYC    = 78,
  parameter int unsigned REF_PERIOD = 150,
  parameter int unsigned REF_LEN    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       preempt_n,
  input  logic       burst_n,
  input  logic [3:0] arb_bus,
  input  logic       err_clr,
  output logic       arb_phase,
  output logic [3:0] owner_lvl,
  output logic       refresh_own,
  output logic       bus_err
);
  logic ref_pend;
  logic ref_take;
  logic ev_sample;

  arbc_refresh_pacer #(.PERIOD(REF_PERIOD)) u_pacer (
    .clk  (clk),
    .rst_n(rst_n),
    .take (ref_take),
    .pend (ref_pend)
  );

  arbc_seq #(
    .SETTLE_CYC(SETTLE_CYC),
    .TMO_CYC   (TMO_CYC),
    .REF_LEN   (REF_LEN)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .preempt_n (preempt_n),
    .burst_n   (burst_n),
    .ref_pend  (ref_pend),
    .err_clr   (err_clr),
    .arb_phase (arb_phase),
    .in_refresh(refresh_own),
    .err       (bus_err),
    .ev_sample (ev_sample),
    .ref_take  (ref_take)
  );

  arbc_level_latch #(.LW(4)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_sample),
    .arb_bus  (arb_bus),
    .owner_lvl(owner_lvl)
  );

endmodule

// File: tb/bus_arbiter_hub_bench.sv
`timescale 1ns/1ps
module bus_arbiter_hub_bench;

  localparam int CLK_PERIOD = 10;
  localparam int S  = 3;
  localparam int T  = 10;
  localparam int P  = 5000;
  localparam int L  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       preempt_n = 1'b1;
  logic       burst_n = 1'b1;
  logic [3:0] arb_bus = 4'hF;
  logic       err_clr = 1'b0;
  logic       arb_phase;
  logic [3:0] owner_lvl;
  logic       refresh_own;
  logic       bus_err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_arbiter_hub #(
    .SETTLE_CYC(S), .TMO_CYC(T), .REF_PERIOD(P), .REF_LEN(L)
  ) u_bus_arbiter_hub (
    .clk(clk), .rst_n(rst_n), .preempt_n(preempt_n), .burst_n(burst_n),
    .arb_bus(arb_bus), .err_clr(err_clr), .arb_phase(arb_phase),
    .owner_lvl(owner_lvl), .refresh_own(refresh_own), .bus_err(bus_err)
  );

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // wired resolution of two agents: the lower level wins, 15 = nobody
  function automatic logic [3:0] resolve(int a, int b);
    return 4'((a < b) ? a : b);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; preempt_n = 1'b1; burst_n = 1'b1; err_clr = 1'b0; arb_bus = 4'hF;
    repeat (3) tick();
    check("R1 arb_phase", int'(arb_phase), 0);
    check("R1 owner_lvl", int'(owner_lvl), 15);
    check("R1 refresh_own", int'(refresh_own), 0);
    check("R1 bus_err", int'(bus_err), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // ---- refresh pacing and priority (R8) ----
    do_reset();
    arb_bus = 4'h0;                         // interrupt requester present
    repeat (P) tick();
    check("R8 before open", int'(arb_phase), 0);
    tick();
    check("R8 opens arb", int'(arb_phase), 1);
    repeat (S) tick();
    check("R8 refresh_own", int'(refresh_own), 1);
    check("R8 grant phase", int'(arb_phase), 0);
    repeat (L-1) tick();
    check("R8 tenure", int'(refresh_own), 1);
    tick();
    check("R8 tenure end", int'(refresh_own), 0);
    check("R8 rearb", int'(arb_phase), 1);
    repeat (S) tick();
    check("R8 back to nmi", int'(owner_lvl), 0);
    check("R8 back grant", int'(arb_phase), 0);

    // ---- level sweep (R3, R4) ----
    do_reset();
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        preempt_n = 1'b0;
        arb_bus = resolve(a, b);
        tick();
        check("R3 preempt", int'(arb_phase), 1);
        preempt_n = 1'b1;
        repeat (S-1) tick();
        check("R4 still arb", int'(arb_phase), 1);
        tick();
        check("R4 granted", int'(arb_phase), 0);
        check("R4 winner", int'(owner_lvl), int'(resolve(a, b)));
      end
    end

    // ---- grant holds under burst, bus changes ignored (R2) ----
    burst_n = 1'b0;
    for (int k = 0; k < 20; k++) begin
      arb_bus = 4'(k);
      tick();
      check("R2 phase", int'(arb_phase), 0);
      check("R2 owner", int'(owner_lvl), 15);
    end
    check("R2 err", int'(bus_err), 0);
    burst_n = 1'b1;

    // ---- release point sweep (R5, R6, R7, R9) ----
    do_reset();
    for (int rel = 1; rel <= T + 1; rel++) begin
      arb_bus = 4'(rel);
      burst_n = 1'b0;
      tick();
      preempt_n = 1'b0;
      tick();
      check("R5 preempt over burst", int'(arb_phase), 1);
      preempt_n = 1'b1;
      for (int k = 1; k <= T; k++) begin
        if (k == rel) burst_n = 1'b1;
        tick();
        if (k < T) check("R9 no early err", int'(bus_err), 0);
      end
      if (rel > T) begin
        check("R6 err", int'(bus_err), 1);
        check("R6 arb held", int'(arb_phase), 1);
        burst_n = 1'b1;
        repeat (4) tick();
        check("R7 sticky", int'(bus_err), 1);
        check("R6 still arb", int'(arb_phase), 1);
        err_clr = 1'b1;
        tick();
        err_clr = 1'b0;
        check("R7 cleared", int'(bus_err), 0);
        check("R7 rearb", int'(arb_phase), 1);
        repeat (S) tick();
        check("R7 grant", int'(arb_phase), 0);
        check("R7 winner", int'(owner_lvl), rel);
      end else begin
        check("R9 no err", int'(bus_err), 0);
        if (rel + S > T) begin
          check("R5 waiting", int'(arb_phase), 1);
          repeat (rel + S - T) tick();
        end
        check("R5 granted", int'(arb_phase), 0);
        check("R5 winner", int'(owner_lvl), rel);
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule